// File: doc/BRIEF.md
# Word Block-Move Engine

This block copies a region of memory from a source pointer to a destination pointer in 16-bit units, or in 32-bit units when long-word mode is selected. A start pulse loads the source pointer, the destination pointer, a 16-bit byte count and four mode bits: repeat, direction, long-word and 64K-wrap compatibility. Each step reads one unit at the source and writes it at the destination, then moves both pointers and lowers the count by the unit size.

A single-step run makes one step. A repeating run keeps stepping while the count, before the step, is larger than the unit size. Every memory access is a request that stays asserted until the memory raises ready. When the last write completes, the block pulses done and shows the updated pointers and count on its outputs. A start with an odd pointer makes no access. It sets an alignment-error flag and pulses done.

Top module: `wmv_engine`

## Requirements
- R1: An incrementing step reads the unit at the source pointer, writes that data at the destination pointer, then adds the unit size to both pointers and subtracts it from the count. The unit size is 2 bytes in word mode.
- R2: A decrementing step (dir_dec=1) moves data the same way but subtracts the unit size from both pointers.
- R3: With rpt=1 the engine starts another step after each write while the count before that step was greater than the unit size. It stops when the count reaches zero.
- R4: With long_mode=1 every access carries 32 bits with mem_wide=1, and the pointers and the count change by 4 per step. With long_mode=0, mem_wide=0 and only mem_wdata[15:0] is meaningful.
- R5: With compat_mode=1, pointer bits 15..0 wrap modulo 65536 and the bits above 15 keep their value. With compat_mode=0 the full pointer carries.
- R6: If bit 0 of src_in or dst_in is 1 at start, no memory request is made and align_err is set until the next start. Done pulses, and the outputs show the supplied values unchanged.
- R7: A memory request holds mem_req, mem_we and mem_addr steady until mem_rdy is sampled high. All pointer addresses are even.
- R8: done is high for exactly one cycle, in the cycle after the last write is accepted. busy is high only while accesses are pending.
- R9: A repeating run started with a count no greater than the unit size, including zero, performs exactly one step. The count wraps modulo 65536, so zero in word mode ends as 0xFFFE.
- R10: During and just after reset, busy, done, align_err and mem_req are 0 and the pointer and count outputs are 0.
- R11: start is ignored while a run is in progress. Inputs other than start are sampled only on the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| rpt | input | 1 | Repeating form |
| dir_dec | input | 1 | 1 = decrementing pointers |
| long_mode | input | 1 | 1 = 32-bit units |
| compat_mode | input | 1 | 1 = wrap pointer updates within 64K |
| src_in | input | 32 | Source pointer at start |
| dst_in | input | 32 | Destination pointer at start |
| cnt_in | input | 16 | Byte count at start |
| busy | output | 1 | Accesses pending |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | Last start had an odd pointer |
| src_out | output | 32 | Current source pointer |
| dst_out | output | 32 | Current destination pointer |
| cnt_out | output | 16 | Current count |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 32-bit access |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rdy | input | 1 | Memory accepts the current request |

## Verification
The bench pushes zero and sub-step counts into repeating runs. A design that compared for equality with zero would not stop and would spill into an unexpected access. It runs the same pointers across a 64K boundary with compat_mode set and then cleared. Carrying into bit 16, or failing to carry, would give the wrong second address. Odd pointers at start must produce no access at all. Start pulses during a run and ready latencies of up to five cycles catch a design that reloads its registers mid-run or moves its address before ready.

// File: rtl/wmv_pkg.sv
package wmv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } wmv_state_e;

  // Bytes moved per step: one word, or two words in long mode.
  function automatic int unsigned step_bytes(input logic lng, input int unsigned word_w);
    return lng ? (2 * (word_w / 8)) : (word_w / 8);
  endfunction

endpackage

// File: rtl/wmv_rst_sync.sv
module wmv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;
endmodule

// File: rtl/wmv_ptr_step.sv
module wmv_ptr_step #(
  parameter int ADDR_W = 32,
  parameter int WRAP_W = 16,
  parameter int WORD_W = 16
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic              lng,
  input  logic              dec,
  input  logic              compat,
  output logic [ADDR_W-1:0] nxt
);
  import wmv_pkg::*;

  logic [ADDR_W-1:0] stp;
  logic [ADDR_W-1:0] full;
  logic [WRAP_W-1:0] low;

  always_comb begin
    stp  = ADDR_W'(step_bytes(lng, WORD_W));
    full = dec ? (ptr - stp) : (ptr + stp);
    low  = dec ? (ptr[WRAP_W-1:0] - stp[WRAP_W-1:0])
               : (ptr[WRAP_W-1:0] + stp[WRAP_W-1:0]);
  end

  generate
    if (WRAP_W < ADDR_W) begin : g_wrap
      assign nxt = compat ? {ptr[ADDR_W-1:WRAP_W], low} : full;
    end else begin : g_nowrap
      logic unused_bits;
      assign unused_bits = compat ^ (^low);
      assign nxt = full;
    end
  endgenerate
endmodule

// File: rtl/wmv_count.sv
module wmv_count #(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             lng,
  input  logic             rpt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             more
);
  import wmv_pkg::*;

  logic [CNT_W-1:0] stp;

  always_comb begin
    stp     = CNT_W'(step_bytes(lng, WORD_W));
    cnt_nxt = cnt - stp;
    // Another step only if this one does not reach or cross zero.
    more    = rpt && (cnt > stp);
  end
endmodule

// File: rtl/wmv_ctrl.sv
module wmv_ctrl (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic                 start,
  input  logic                 misalign,
  input  logic                 mem_rdy,
  input  logic                 more,
  output wmv_pkg::wmv_state_e  state,
  output logic                 ld_go,
  output logic                 rd_acc,
  output logic                 wr_acc
);
  import wmv_pkg::*;

  wmv_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ld_go   = 1'b0;
    rd_acc  = 1'b0;
    wr_acc  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ld_go   = 1'b1;
          state_d = misalign ? ST_FIN : ST_RD;
        end
      end
      ST_RD: begin
        if (mem_rdy) begin
          rd_acc  = 1'b1;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (mem_rdy) begin
          wr_acc  = 1'b1;
          state_d = more ? ST_RD : ST_FIN;
        end
      end
      ST_FIN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state = state_q;

  // R3: a write accepted with more steps due goes back to reading
  a_r3_next_read: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_WR && mem_rdy && more) |=> (state_q == ST_RD));
endmodule

// File: rtl/wmv_engine.sv
module wmv_engine #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16,
  parameter int WRAP_W = 16,
  localparam int DATA_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rpt,
  input  logic              dir_dec,
  input  logic              long_mode,
  input  logic              compat_mode,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  output logic              busy,
  output logic              done,
  output logic              align_err,
  output logic [ADDR_W-1:0] src_out,
  output logic [ADDR_W-1:0] dst_out,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy
);
  import wmv_pkg::*;

  logic              rst_sn;
  wmv_state_e        state;
  logic              ld_go, rd_acc, wr_acc, more, misalign;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              rpt_q, dec_q, long_q, compat_q, err_q;
  logic [DATA_W-1:0] buf_q;
  logic [ADDR_W-1:0] ptr_cur [2];
  logic [ADDR_W-1:0] ptr_nxt [2];

  wmv_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign misalign = src_in[0] | dst_in[0];

  wmv_ctrl u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .start(start), .misalign(misalign),
    .mem_rdy(mem_rdy), .more(more), .state(state),
    .ld_go(ld_go), .rd_acc(rd_acc), .wr_acc(wr_acc)
  );

  assign ptr_cur[0] = src_q;
  assign ptr_cur[1] = dst_q;

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    wmv_ptr_step #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W), .WORD_W(WORD_W)) u_step (
      .ptr(ptr_cur[g]), .lng(long_q), .dec(dec_q), .compat(compat_q), .nxt(ptr_nxt[g])
    );
  end

  wmv_count #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
    .cnt(cnt_q), .lng(long_q), .rpt(rpt_q), .cnt_nxt(cnt_nxt), .more(more)
  );

  // Register file: loaded on an accepted start, advanced on each accepted write.
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      rpt_q    <= 1'b0;
      dec_q    <= 1'b0;
      long_q   <= 1'b0;
      compat_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (ld_go) begin
      src_q    <= src_in;
      dst_q    <= dst_in;
      cnt_q    <= cnt_in;
      rpt_q    <= rpt;
      dec_q    <= dir_dec;
      long_q   <= long_mode;
      compat_q <= compat_mode;
      err_q    <= misalign;
    end else if (wr_acc) begin
      src_q    <= ptr_nxt[0];
      dst_q    <= ptr_nxt[1];
      cnt_q    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     buf_q <= '0;
    else if (rd_acc) buf_q <= mem_rdata;
  end

  assign busy      = (state == ST_RD) || (state == ST_WR);
  assign done      = (state == ST_FIN);
  assign align_err = err_q;
  assign src_out   = src_q;
  assign dst_out   = dst_q;
  assign cnt_out   = cnt_q;
  assign mem_req   = busy;
  assign mem_we    = (state == ST_WR);
  assign mem_wide  = long_q;
  assign mem_addr  = (state == ST_WR) ? dst_q : src_q;
  assign mem_wdata = long_q ? buf_q : {{WORD_W{1'b0}}, buf_q[WORD_W-1:0]};

  // R7: a pending request keeps its address and direction
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7: addresses issued are even
  a_r7_even_addr: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> !mem_addr[0]);

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  // R8: a normal completion follows an accepted write
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && mem_we && mem_rdy && !more) |=> done);

  // R6: a misaligned start produces no access
  a_r6_quiet_on_error: assert property (@(posedge clk) disable iff (!rst_sn)
    align_err |-> !mem_req);

  // R11: a start during a run leaves the latched mode alone
  a_r11_mode_kept: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && $past(busy)) |-> $stable(mem_wide));
endmodule

// File: tb/wmv_engine_tb.sv
module wmv_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, rpt, dir_dec, long_mode, compat_mode;
  logic [31:0] src_in, dst_in;
  logic [15:0] cnt_in;
  logic        busy, done, align_err;
  logic [31:0] src_out, dst_out;
  logic [15:0] cnt_out;
  logic        mem_req, mem_we, mem_wide;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  wmv_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rpt(rpt), .dir_dec(dir_dec),
    .long_mode(long_mode), .compat_mode(compat_mode), .src_in(src_in),
    .dst_in(dst_in), .cnt_in(cnt_in), .busy(busy), .done(done),
    .align_err(align_err), .src_out(src_out), .dst_out(dst_out),
    .cnt_out(cnt_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  typedef struct {
    logic        we;
    logic        wide;
    logic [31:0] addr;
    logic [31:0] data;
  } acc_t;

  acc_t        exp_q[$];
  string       tag_q[$];
  logic [7:0]  mem [logic [31:0]];
  int          total = 0;
  int          bad   = 0;
  int          lat   = 0;
  int          wait_cnt = 0;

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  // Memory model and scoreboard monitor, acting at the falling edge.
  always @(negedge clk) begin
    if (mem_rdy) begin
      mem_rdy  = 1'b0;
      wait_cnt = lat;
    end else if (mem_req && rst_n) begin
      if (wait_cnt > 0) begin
        wait_cnt--;
      end else begin
        acc_t  e;
        string t;
        int    nb;
        mem_rdy = 1'b1;
        nb = mem_wide ? 4 : 2;
        if (!mem_we) begin
          for (int i = 0; i < 4; i++) mem_rdata[8*i +: 8] = rd_byte(mem_addr + 32'(i));
        end else begin
          for (int i = 0; i < nb; i++) mem[mem_addr + 32'(i)] = mem_wdata[8*i +: 8];
        end
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R11 unexpected access act=%h exp=none", mem_addr);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, "access we", {31'd0, mem_we}, {31'd0, e.we});
          check(t, "access wide (R4)", {31'd0, mem_wide}, {31'd0, e.wide});
          check(t, "access addr", mem_addr, e.addr);
          if (e.we) begin
            if (e.wide) check(t, "write data", mem_wdata, e.data);
            else        check(t, "write data", {16'd0, mem_wdata[15:0]}, e.data);
          end
        end
      end
    end
  end

  // Driver: models the run, queues expected accesses, then drives and checks.
  task automatic run_move(input string tag, input logic [31:0] s0, input logic [31:0] d0,
                          input logic [15:0] c0, input logic r, input logic dec,
                          input logic lng, input logic cmp, input int latency,
                          input logic poke);
    logic [31:0] s, d, nxt_s, nxt_d;
    logic [15:0] c, stp;
    logic        go, odd;
    int          n;
    s = s0; d = d0; c = c0;
    stp = lng ? 16'd4 : 16'd2;
    odd = s0[0] | d0[0];
    go  = !odd;
    while (go) begin
      acc_t rd, wr;
      rd.we = 1'b0; rd.wide = lng; rd.addr = s; rd.data = '0;
      wr.we = 1'b1; wr.wide = lng; wr.addr = d; wr.data = '0;
      for (int i = 0; i < (lng ? 4 : 2); i++) wr.data[8*i +: 8] = rd_byte(s + 32'(i));
      exp_q.push_back(rd); tag_q.push_back(tag);
      exp_q.push_back(wr); tag_q.push_back(tag);
      if (cmp) begin
        nxt_s = {s[31:16], dec ? s[15:0] - stp : s[15:0] + stp};
        nxt_d = {d[31:16], dec ? d[15:0] - stp : d[15:0] + stp};
      end else begin
        nxt_s = dec ? s - 32'(stp) : s + 32'(stp);
        nxt_d = dec ? d - 32'(stp) : d + 32'(stp);
      end
      go = r && (c > stp);
      s = nxt_s; d = nxt_d; c = c - stp;
    end
    lat = latency;
    wait_cnt = latency;
    @(negedge clk);
    src_in = s0; dst_in = d0; cnt_in = c0; rpt = r; dir_dec = dec;
    long_mode = lng; compat_mode = cmp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    src_in = 32'hFFFF_FFF1; dst_in = 32'h0; cnt_in = 16'h1234;
    rpt = ~r; dir_dec = ~dec; long_mode = ~lng; compat_mode = ~cmp;
    if (!odd) check(tag, "busy during run (R8)", {31'd0, busy}, 32'd1);
    if (poke) begin
      // R11: start pulses mid-run with changed inputs
      src_in = 32'h0000_0100; dst_in = 32'h0000_0200;
      start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(tag, "done seen (R8)", {31'd0, done}, 32'd1);
    check(tag, "src_out", src_out, odd ? s0 : s);
    check(tag, "dst_out", dst_out, odd ? d0 : d);
    check(tag, "cnt_out", {16'd0, cnt_out}, odd ? {16'd0, c0} : {16'd0, c});
    check(tag, "align_err (R6)", {31'd0, align_err}, {31'd0, odd});
    check(tag, "queue drained", 32'(exp_q.size()), 32'd0);
    @(negedge clk);
    check(tag, "done single cycle (R8)", {31'd0, done}, 32'd0);
    check(tag, "busy after run (R8)", {31'd0, busy}, 32'd0);
    repeat (2) @(negedge clk);
    check(tag, "no stray access (R11)", {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rpt = 1'b0; dir_dec = 1'b0; long_mode = 1'b0;
    compat_mode = 1'b0; src_in = '0; dst_in = '0; cnt_in = '0;
    mem_rdy = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10", "busy", {31'd0, busy}, 32'd0);
    check("R10", "done", {31'd0, done}, 32'd0);
    check("R10", "align_err", {31'd0, align_err}, 32'd0);
    check("R10", "mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "src_out after release", src_out, 32'd0);
    check("R10", "cnt_out after release", {16'd0, cnt_out}, 32'd0);

    run_move("R1", 32'h0000_1000, 32'h0000_2000, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    run_move("R2", 32'h0000_1100, 32'h0000_2100, 16'h0010, 1'b0, 1'b1, 1'b0, 1'b0, 2, 1'b0);
    run_move("R3", 32'h0000_1200, 32'h0000_2200, 16'h0006, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1'b0);
    run_move("R3", 32'h0000_1310, 32'h0000_2310, 16'h0008, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    run_move("R4", 32'h0000_1400, 32'h0000_2400, 16'h000C, 1'b1, 1'b0, 1'b1, 1'b0, 1, 1'b0);
    run_move("R4", 32'h0000_1500, 32'h0000_2500, 16'h0020, 1'b0, 1'b1, 1'b1, 1'b0, 3, 1'b0);
    run_move("R5", 32'h0003_FFFC, 32'h0005_FFFE, 16'h0006, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b0);
    run_move("R5", 32'h0001_0002, 32'h0007_0006, 16'h0008, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1'b0);
    run_move("R5", 32'h0009_FFFC, 32'h000B_FFFE, 16'h0006, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    run_move("R9", 32'h0000_1600, 32'h0000_2600, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    run_move("R9", 32'h0000_1700, 32'h0000_2700, 16'h0002, 1'b1, 1'b0, 1'b1, 1'b0, 1, 1'b0);
    run_move("R6", 32'h0000_1801, 32'h0000_2800, 16'h0008, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    run_move("R6", 32'h0000_1900, 32'h0000_2903, 16'h0008, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    run_move("R1", 32'h0000_1A00, 32'h0000_2A00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    run_move("R11", 32'h0000_1B00, 32'h0000_2B00, 16'h000A, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b1);
    run_move("R7", 32'h0000_1C00, 32'h0000_2C00, 16'h0008, 1'b1, 1'b0, 1'b1, 1'b0, 5, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule